// File: doc/BRIEF.md
# Address-Filtering Serial Receiver

This block receives asynchronous serial frames on a multi-drop line where one master talks to many listeners. Each frame carries five to nine data bits. A frame-type bit marks the frame as an address frame (one) or a data frame (zero). With five to eight data bits, the first stop bit serves as the type bit. With nine data bits, the ninth data bit serves as the type bit.

When filtering is on, only address frames reach the two-entry receive buffer, so a listener's host sees only addresses. After the host recognises its own address, it turns filtering off and takes the data frames that follow. Each buffered frame keeps its data, its type bit and a framing-error flag. A sticky overrun flag records frames lost because the buffer was full.

A divisor sets the oversampling tick rate. A speed control selects 16 or 8 ticks per bit, and each bit is decided by a vote of three samples at its centre.

Top module: `uaf_rx_top`

## Requirements
- R1: Data bits arrive least significant first. A frame of N bits (N = 5..9) appears in `rd_data_o[N-1:0]`, and the bits above N read zero.
- R2: The type bit is the value of the first stop bit for N = 5..8, and data bit 8 for N = 9. It is shown on `rd_type_o`, where one means address.
- R3: With filtering on, a frame whose type bit is zero is never written to the buffer, and no framing error is reported for it.
- R4: With filtering off, every completed frame is written to the buffer, whatever its type bit.
- R5: `rd_ferr_o` is one when the sampled stop bit is zero. The exception is a five-to-eight-bit frame under filtering, which is dropped instead.
- R6: A tick occurs every `divisor_i`+1 clocks. A bit lasts 16 ticks when `dspeed_i`=0 and 8 ticks when `dspeed_i`=1.
- R7: Each bit is the majority of three samples at the bit centre, so a low glitch one tick wide inside a data bit does not change the data.
- R8: A start edge whose centre vote reads high is a false start. The receiver goes back to idle and writes nothing.
- R9: The buffer holds two frames in arrival order. `rd_valid_o` is high while it is non-empty, and a cycle with `rd_en_i` high removes the head frame.
- R10: A frame that completes while the buffer is full is dropped and sets `overrun_o`. The flag stays set until a read removes a frame.
- R11: `filt_en_i`, `dspeed_i` and `len_i` are captured at the start bit. A change during a frame applies from the next frame.
- R12: After reset, the buffer is empty and `overrun_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Serial input, idle high |
| divisor_i | input | DIV_W | Tick period minus one, in clocks |
| dspeed_i | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| len_i | input | 4 | Data bits per frame, 5..9 |
| filt_en_i | input | 1 | Drop frames whose type bit is zero |
| rd_en_i | input | 1 | Remove the head frame from the buffer |
| rd_valid_o | output | 1 | Buffer holds at least one frame |
| rd_data_o | output | 9 | Data of the head frame |
| rd_type_o | output | 1 | Type bit of the head frame |
| rd_ferr_o | output | 1 | Framing error of the head frame |
| overrun_o | output | 1 | Sticky lost-frame flag |

## Verification
The assertions check the buffer and flag discipline on every cycle:
- the overrun flag stays set until a read, and rises only when the buffer is full;
- the valid flag falls only after a read, and the head data stays stable while it waits;
- no frame typed as data is ever written while the filter setting captured at its start is on.

Only the bench's scenarios can show the rest, by sweeping lengths, speeds, types and filter settings:
- correct bit extraction and type-bit selection;
- the framing-error exceptions;
- glitch rejection, false-start recovery;
- the point at which a filter change takes effect.

// File: rtl/uaf_pkg.sv
package uaf_pkg;
  localparam int MAX_BITS = 9;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic                ferr;
    logic                ftype;
    logic [MAX_BITS-1:0] data;
  } uaf_frame_t;
endpackage

// File: rtl/uaf_tick_gen.sv
module uaf_tick_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= divisor_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uaf_rx_core.sv
module uaf_rx_core
  import uaf_pkg::*;
#(
  parameter int OSR_N = 16,
  parameter int OSR_D = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic       dspeed_i,
  input  logic [3:0] len_i,
  input  logic       filt_i,
  output logic       push_o,
  output uaf_frame_t frame_o,
  output logic       filt_o
);
  localparam int SW = $clog2(OSR_N);

  rx_state_e           state_q;
  logic [SW-1:0]       scnt_q, last_c, mid_c;
  logic                ds_q, filt_q;
  logic [3:0]          len_q, len_c, bit_q;
  logic [1:0]          smp_q;
  logic [MAX_BITS-1:0] data_q;
  logic                vote_c, ftype_c;

  always_comb begin
    if (len_i < 4'd5)      len_c = 4'd5;
    else if (len_i > 4'd9) len_c = 4'd9;
    else                   len_c = len_i;
    last_c  = ds_q ? SW'(OSR_D - 1) : SW'(OSR_N - 1);
    mid_c   = ds_q ? SW'(OSR_D / 2) : SW'(OSR_N / 2);
    vote_c  = (smp_q[0] & smp_q[1]) | (smp_q[0] & rx_i) | (smp_q[1] & rx_i);
    ftype_c = (len_q == 4'd9) ? data_q[8] : vote_c;
  end

  assign filt_o = filt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      scnt_q  <= '0;
      ds_q    <= 1'b0;
      filt_q  <= 1'b0;
      len_q   <= 4'd8;
      bit_q   <= '0;
      smp_q   <= '0;
      data_q  <= '0;
      push_o  <= 1'b0;
      frame_o <= '0;
    end else begin
      push_o <= 1'b0;
      if (tick_i) begin
        if (state_q == RX_IDLE) begin
          if (!rx_i) begin
            state_q <= RX_START;
            scnt_q  <= SW'(1);
            ds_q    <= dspeed_i;
            filt_q  <= filt_i;
            len_q   <= len_c;
            bit_q   <= '0;
            data_q  <= '0;
          end
        end else begin
          scnt_q <= (scnt_q == last_c) ? '0 : scnt_q + 1'b1;
          if (scnt_q == mid_c - 1'b1) smp_q[0] <= rx_i;
          if (scnt_q == mid_c)        smp_q[1] <= rx_i;
          if (scnt_q == mid_c + 1'b1) begin
            case (state_q)
              RX_START: if (vote_c) state_q <= RX_IDLE;
              RX_DATA:  data_q[bit_q] <= vote_c;
              RX_STOP: begin
                state_q       <= RX_IDLE;
                push_o        <= !(filt_q && !ftype_c);
                frame_o.data  <= data_q;
                frame_o.ftype <= ftype_c;
                frame_o.ferr  <= !vote_c && !(filt_q && len_q != 4'd9);
              end
              default: ;
            endcase
          end
          if (scnt_q == last_c) begin
            if (state_q == RX_START) begin
              state_q <= RX_DATA;
            end else if (state_q == RX_DATA) begin
              if (bit_q == len_q - 1'b1) state_q <= RX_STOP;
              else                       bit_q   <= bit_q + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/uaf_fifo.sv
module uaf_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_i,
  output logic [W-1:0] rd_data_o,
  output logic         valid_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign full_o    = (cnt_q == CW'(DEPTH));
  assign valid_o   = (cnt_q != '0);
  assign do_wr     = wr_en_i && !full_o;
  assign do_rd     = rd_en_i && valid_o;
  assign rd_data_o = mem_q[rp_q];

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wp_q] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_rd) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_wr) - CW'(do_rd);
    end
  end
endmodule

// File: rtl/uaf_rx_top.sv
module uaf_rx_top
  import uaf_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int OSR_N = 16,
  parameter int OSR_D = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxd_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             dspeed_i,
  input  logic [3:0]       len_i,
  input  logic             filt_en_i,
  input  logic             rd_en_i,
  output logic             rd_valid_o,
  output logic [8:0]       rd_data_o,
  output logic             rd_type_o,
  output logic             rd_ferr_o,
  output logic             overrun_o
);
  localparam int FW = $bits(uaf_frame_t);

  logic [1:0] sync_q;
  logic       tick;
  logic       core_push, core_filt, buf_full;
  uaf_frame_t core_frame, head;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rxd_i};
  end

  uaf_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst(rst), .divisor_i(divisor_i), .tick_o(tick)
  );

  uaf_rx_core #(.OSR_N(OSR_N), .OSR_D(OSR_D)) core_i (
    .clk(clk), .rst(rst), .tick_i(tick), .rx_i(sync_q[1]),
    .dspeed_i(dspeed_i), .len_i(len_i), .filt_i(filt_en_i),
    .push_o(core_push), .frame_o(core_frame), .filt_o(core_filt)
  );

  uaf_fifo #(.W(FW), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .wr_en_i(core_push), .wr_data_i(core_frame),
    .rd_en_i(rd_en_i), .rd_data_o(head), .valid_o(rd_valid_o), .full_o(buf_full)
  );

  always_ff @(posedge clk) begin
    if (rst)                           overrun_o <= 1'b0;
    else if (core_push && buf_full)    overrun_o <= 1'b1;
    else if (rd_en_i && rd_valid_o)    overrun_o <= 1'b0;
  end

  assign rd_data_o = head.data;
  assign rd_type_o = head.ftype;
  assign rd_ferr_o = head.ferr;
endmodule

// File: rtl/uaf_rx_chk.sv
module uaf_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_en_i,
  input logic       rd_valid_o,
  input logic [8:0] rd_data_o,
  input logic       overrun_o,
  input logic       buf_full,
  input logic       core_push,
  input logic       core_type,
  input logic       core_filt
);
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun_o && !rd_en_i |=> overrun_o); // R10

  AST_OVERRUN_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_o) |-> $past(buf_full)); // R10

  AST_NO_DATA_FRAME_FILTERED: assert property (@(posedge clk) disable iff (rst)
    core_push && core_filt |-> core_type); // R3

  AST_VALID_FALLS_ON_READ: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_valid_o) |-> $past(rd_en_i)); // R9

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o && !rd_en_i |=> $stable(rd_data_o)); // R9
endmodule

bind uaf_rx_top uaf_rx_chk chk_i (
  .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .rd_valid_o(rd_valid_o),
  .rd_data_o(rd_data_o), .overrun_o(overrun_o), .buf_full(buf_full),
  .core_push(core_push), .core_type(core_frame.ftype), .core_filt(core_filt)
);

// File: tb/uaf_rx_top_tb_top.sv
module uaf_rx_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxd = 1'b1;
  logic [11:0] divisor = 12'd3;
  logic        dspeed = 1'b0;
  logic [3:0]  len = 4'd8;
  logic        filt = 1'b0;
  logic        rd_en = 1'b0;
  logic        rd_valid, rd_type, rd_ferr, overrun;
  logic [8:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uaf_rx_top dut_i (
    .clk(clk), .rst(rst), .rxd_i(rxd), .divisor_i(divisor), .dspeed_i(dspeed),
    .len_i(len), .filt_en_i(filt), .rd_en_i(rd_en), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .rd_type_o(rd_type), .rd_ferr_o(rd_ferr), .overrun_o(overrun)
  );

  function automatic int bit_clks();
    return (dspeed ? 8 : 16) * (int'(divisor) + 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input bit glitch);
    int bc = bit_clks();
    if (!glitch) begin
      rxd = v;
      repeat (bc) @(negedge clk);
    end else begin
      rxd = v;
      repeat (bc / 2 - 2) @(negedge clk);
      rxd = 1'b0;
      repeat (int'(divisor) + 1) @(negedge clk);
      rxd = v;
      repeat (bc - bc / 2 + 2 - int'(divisor) - 1) @(negedge clk);
    end
  endtask

  // Start bit, n data bits LSB first, stop bit, two idle bits
  task automatic send(input int n, input logic [8:0] d, input logic stop, input int gl);
    drive_bit(1'b0, 0);
    for (int i = 0; i < n; i++) drive_bit(d[i], i == gl);
    drive_bit(stop, 0);
    drive_bit(1'b1, 0);
    drive_bit(1'b1, 0);
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R12 valid after reset", rd_valid, 0);
    check("R12 overrun after reset", overrun, 0);

    // Sweep: speed x filter x length x type x pattern (R1 R2 R3 R4 R5 R6)
    for (int ds = 0; ds < 2; ds++)
      for (int f = 0; f < 2; f++)
        for (int n = 5; n <= 9; n++)
          for (int t = 0; t < 2; t++)
            for (int p = 0; p < 2; p++) begin
              logic [8:0] d, exp_d;
              logic stop;
              bit pushed;
              int exp_ferr;
              dspeed = ds[0];
              filt = f[0];
              len = 4'(n);
              d = (p ? 9'h155 : 9'h0CB) ^ 9'(n * 37);
              d = d & 9'((1 << n) - 1);
              if (n == 9) begin
                d[8] = t[0];
                stop = 1'b1;
              end else begin
                stop = t[0];
              end
              exp_d = d;
              pushed = !f[0] || t[0];
              exp_ferr = (n == 9) ? 0 : (t == 0 ? 1 : 0);
              send(n, d, stop, -1);
              if (pushed) begin
                check("R4 frame buffered", rd_valid, 1);
                check("R1 data bits", int'(rd_data), int'(exp_d));
                check("R2 type bit", rd_type, t);
                check("R5 framing error", rd_ferr, exp_ferr);
                pop();
                check("R9 empty after read", rd_valid, 0);
              end else begin
                check("R3 data frame dropped", rd_valid, 0);
              end
            end

    // Nine-bit frame with low stop bit (R5)
    dspeed = 1'b0; filt = 1'b0; len = 4'd9;
    send(9, 9'h1A3, 1'b0, -1);
    check("R5 nine-bit stop error", rd_ferr, 1);
    check("R2 nine-bit type", rd_type, 1);
    pop();

    // Slower divisor (R6)
    divisor = 12'd7; len = 4'd8;
    send(8, 9'h0C6, 1'b1, -1);
    check("R6 divisor 7 data", int'(rd_data), 'hC6);
    pop();
    divisor = 12'd3;

    // Glitch inside a data bit (R7)
    send(8, 9'h0FF, 1'b1, 3);
    check("R7 glitch rejected", int'(rd_data), 'hFF);
    pop();
    dspeed = 1'b1;
    send(8, 9'h0F0, 1'b1, 5);
    check("R7 glitch rejected double speed", int'(rd_data), 'hF0);
    pop();
    dspeed = 1'b0;

    // False start (R8)
    rxd = 1'b0;
    repeat (int'(divisor) + 1) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * bit_clks()) @(negedge clk);
    check("R8 false start writes nothing", rd_valid, 0);
    send(8, 9'h05A, 1'b1, -1);
    check("R8 frame after false start", int'(rd_data), 'h5A);
    pop();

    // Overrun (R9 R10)
    send(8, 9'h011, 1'b1, -1);
    send(8, 9'h022, 1'b1, -1);
    check("R10 no overrun at two", overrun, 0);
    send(8, 9'h033, 1'b1, -1);
    check("R10 overrun set", overrun, 1);
    check("R9 head is first", int'(rd_data), 'h11);
    pop();
    check("R10 overrun cleared by read", overrun, 0);
    check("R9 second in order", int'(rd_data), 'h22);
    pop();
    check("R10 third frame dropped", rd_valid, 0);

    // Filter change mid-frame (R11)
    filt = 1'b1;
    fork
      send(8, 9'h044, 1'b0, -1);
      begin
        repeat (3 * bit_clks()) @(negedge clk);
        filt = 1'b0;
      end
    join
    check("R11 filter on at start still drops", rd_valid, 0);
    filt = 1'b0;
    fork
      send(8, 9'h066, 1'b0, -1);
      begin
        repeat (3 * bit_clks()) @(negedge clk);
        filt = 1'b1;
      end
    join
    check("R11 filter off at start keeps frame", rd_valid, 1);
    check("R11 kept frame data", int'(rd_data), 'h66);
    check("R11 kept frame error", rd_ferr, 1);
    pop();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule